// File: doc/BRIEF.md
# Microstepping Phase Current Translator

This block turns a pulse train on a step input into current setpoints for the two windings of a bipolar stepper motor. It holds a position index inside an electrical cycle of 64 entries, 5.625 degrees each. On every accepted rising edge of the step input it moves that index by a stride of 16, 8, 4 or 1 entries, forward or backward. From the index it derives a signed magnitude for each phase from a quarter-wave sine table. Phase 1 follows the cosine of the index angle and phase 2 follows the sine. It also chooses, for each phase, whether the downstream current regulator should use slow or mixed decay.

The step, direction and resolution inputs are brought into the clock domain by synchronizers. A small state machine qualifies the step input. Its states are `QS_IDLE`, which waits for the input to go high, `QS_COUNT`, which counts the cycles the input stays high, and `QS_WAIT_LOW`, which waits for the input to fall again. The transitions are:
- IDLE to COUNT when the input rises, and the direction and resolution are captured at that moment.
- COUNT back to IDLE when the input falls before the minimum high time.
- COUNT to WAIT_LOW when the high time is reached, and the step is applied at that moment.
- WAIT_LOW to IDLE when the input falls.
- Any state to WAIT_LOW while the park input is high.

A park input acts as the functional reset: it holds the index at home and blocks the bridges. A separate output-off input blocks only the bridge enable.

Top module: `ustep_translator`

## Requirements
- R1: `res_sel` = 2'b00 moves 16 entries per step, 2'b10 moves 8, 2'b01 moves 4 and 2'b11 moves 1. Bit 1 of `res_sel` is the first select line.
- R2: Magnitudes are 8-bit codes on a 0..255 scale. For quarter-wave positions 0..16 from a peak they are 255,254,250,244,236,225,212,197,180,162,142,120,98,74,50,25,0. Phase 1 is the cosine of index×5.625°, and phase 2 is the sine.
- R3: A phase is negative (`phN_neg`=1) when its cosine or sine is below zero. A zero magnitude is always reported with `phN_neg`=0.
- R4: After `rst_n` low, and one cycle after `park` is high, the index is home (index 8, 45°). Both magnitudes are then 180 and both signs are positive.
- R5: While `park` is high, step pulses are ignored and `drive_en` is 0.
- R6: `dir_in`=1 increases the index and `dir_in`=0 decreases it, modulo 64.
- R7: Direction and resolution are captured when the step input rises. Changing them while the step input is high does not alter that step.
- R8: A step takes effect only if the synchronized step input stays high for at least `MIN_HIGH` consecutive clocks. A pulse one clock shorter moves nothing.
- R9: After each applied step, a phase whose new magnitude is below its old magnitude reports mixed decay (`phN_mixed`=1). A phase whose new magnitude is equal or higher reports slow decay (`phN_mixed`=0).
- R10: After reset or park, both phases report mixed decay until the next applied step.
- R11: `out_off`=1 forces `drive_en` to 0. Stepping, capture and the index keep working while it is set.
- R12: If the index is not a multiple of the new stride, it still advances by exactly the stride from its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| park | input | 1 | Functional reset: forces home, blocks steps and bridges |
| out_off | input | 1 | Forces the bridge enable low |
| step_in | input | 1 | Step pulse, asynchronous |
| dir_in | input | 1 | Direction: 1 increases the angle |
| res_sel | input | 2 | Resolution select |
| drive_en | output | 1 | Bridge enable |
| ph1_mag | output | 8 | Phase 1 magnitude code |
| ph1_neg | output | 1 | Phase 1 current is negative |
| ph2_mag | output | 8 | Phase 2 magnitude code |
| ph2_neg | output | 1 | Phase 2 current is negative |
| ph1_mixed | output | 1 | Phase 1 requests mixed decay |
| ph2_mixed | output | 1 | Phase 2 requests mixed decay |

## Verification
The bench aims at the following corner cases:
- A step pulse exactly at the minimum high time, and one a clock shorter. An off-by-one counter would either drop valid steps or accept glitches.
- Direction flips during a high pulse. Sampling on the wrong event would send the motor the wrong way.
- Index wrap through 0 and 63, and the zero crossings at 90° and 270°. A wrong quadrant decode would show a negative zero or a flipped sign.
- Strides taken from unaligned positions, and equal-magnitude steps. Equal magnitudes must yield slow decay, and a strict/non-strict compare swap would report mixed.
- Park and output-off. These must block the bridges without freezing the sequencer in the output-off case.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int IDX_W = 6;
    localparam int MAG_W = 8;
    localparam int QTR   = 16;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [MAG_W-1:0] mag_t;

    localparam idx_t HOME_IDX = idx_t'(8);
    localparam mag_t HOME_MAG = mag_t'(180);

    typedef enum logic [1:0] {
        RES_FULL      = 2'b00,
        RES_QUARTER   = 2'b01,
        RES_HALF      = 2'b10,
        RES_SIXTEENTH = 2'b11
    } res_e;

    typedef enum logic [1:0] {
        QS_IDLE,
        QS_COUNT,
        QS_WAIT_LOW
    } qstate_e;

    // magnitude at k entries away from a peak (k = 0..16)
    function automatic mag_t qwave(input logic [4:0] k);
        case (k)
            5'd0:    return 8'd255;
            5'd1:    return 8'd254;
            5'd2:    return 8'd250;
            5'd3:    return 8'd244;
            5'd4:    return 8'd236;
            5'd5:    return 8'd225;
            5'd6:    return 8'd212;
            5'd7:    return 8'd197;
            5'd8:    return 8'd180;
            5'd9:    return 8'd162;
            5'd10:   return 8'd142;
            5'd11:   return 8'd120;
            5'd12:   return 8'd98;
            5'd13:   return 8'd74;
            5'd14:   return 8'd50;
            5'd15:   return 8'd25;
            default: return 8'd0;
        endcase
    endfunction

    function automatic idx_t stride_of(input logic [1:0] sel);
        case (sel)
            RES_FULL:    return idx_t'(16);
            RES_HALF:    return idx_t'(8);
            RES_QUARTER: return idx_t'(4);
            default:     return idx_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/ustep_sync.sv
module ustep_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ustep_step_qual.sv
module ustep_step_qual
    import ustep_pkg::*;
#(
    parameter int MIN_HIGH = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic park,
    input  logic step_s,
    output logic rise,
    output logic adv
);

    localparam int CNT_W = $clog2(MIN_HIGH + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_HIGH);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    qstate_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             reached;

    assign reached = (cnt_q + ONE) >= LIMIT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (park) begin
            state_d = QS_WAIT_LOW;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                QS_IDLE: begin
                    if (step_s) begin
                        cnt_d   = ONE;
                        state_d = (LIMIT <= ONE) ? QS_WAIT_LOW : QS_COUNT;
                    end
                end
                QS_COUNT: begin
                    if (!step_s) begin
                        state_d = QS_IDLE;
                        cnt_d   = '0;
                    end else if (reached) begin
                        state_d = QS_WAIT_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                QS_WAIT_LOW: begin
                    if (!step_s) state_d = QS_IDLE;
                end
                default: state_d = QS_IDLE;
            endcase
        end
    end

    always_comb begin
        rise = !park && step_s && (state_q == QS_IDLE);
        adv  = !park && step_s &&
               (((state_q == QS_IDLE) && (LIMIT <= ONE)) ||
                ((state_q == QS_COUNT) && reached));
    end

endmodule

// File: rtl/ustep_phase_lookup.sv
module ustep_phase_lookup
    import ustep_pkg::*;
#(
    parameter bit SINE = 1'b0
) (
    input  idx_t idx,
    output mag_t mag,
    output logic neg
);

    idx_t       a;
    logic [4:0] k;

    always_comb begin
        // sine is the cosine shifted back by a quarter cycle
        a   = SINE ? idx - idx_t'(QTR) : idx;
        k   = a[4] ? 5'(QTR) - {1'b0, a[3:0]} : {1'b0, a[3:0]};
        mag = qwave(k);
        neg = (a[5] ^ a[4]) && (mag != '0);
    end

endmodule

// File: rtl/ustep_translator.sv
module ustep_translator
    import ustep_pkg::*;
#(
    parameter int MIN_HIGH    = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       park,
    input  logic       out_off,
    input  logic       step_in,
    input  logic       dir_in,
    input  logic [1:0] res_sel,
    output logic       drive_en,
    output logic [7:0] ph1_mag,
    output logic       ph1_neg,
    output logic [7:0] ph2_mag,
    output logic       ph2_neg,
    output logic       ph1_mixed,
    output logic       ph2_mixed
);

    localparam int NPH = 2;

    logic       step_s, dir_s;
    logic [1:0] sel_s;

    ustep_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({step_in, dir_in, res_sel}),
        .q     ({step_s, dir_s, sel_s})
    );

    logic rise, adv;

    ustep_step_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .park   (park),
        .step_s (step_s),
        .rise   (rise),
        .adv    (adv)
    );

    logic       dir_l, dir_eff;
    logic [1:0] sel_l, sel_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_l <= 1'b1;
            sel_l <= RES_FULL;
        end else if (rise) begin
            dir_l <= dir_s;
            sel_l <= sel_s;
        end
    end

    assign dir_eff = rise ? dir_s : dir_l;
    assign sel_eff = rise ? sel_s : sel_l;

    idx_t idx, idx_nxt, stride;

    always_comb begin
        stride  = stride_of(sel_eff);
        idx_nxt = dir_eff ? idx + stride : idx - stride;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx <= HOME_IDX;
        else if (park)   idx <= HOME_IDX;
        else if (adv)    idx <= idx_nxt;
    end

    mag_t           mag   [NPH];
    logic           neg   [NPH];
    logic [MAG_W:0] prev  [NPH];
    logic           mixed [NPH];

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        ustep_phase_lookup #(.SINE(g == 1)) u_lut (
            .idx (idx),
            .mag (mag[g]),
            .neg (neg[g])
        );
        assign mixed[g] = {1'b0, mag[g]} < prev[g];
    end

    // prev holds the magnitude before the last step; the out-of-range
    // value after reset makes both phases request mixed decay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPH; p++) prev[p] <= {1'b1, {MAG_W{1'b0}}};
        end else if (park) begin
            for (int p = 0; p < NPH; p++) prev[p] <= {1'b1, {MAG_W{1'b0}}};
        end else if (adv) begin
            for (int p = 0; p < NPH; p++) prev[p] <= {1'b0, mag[p]};
        end
    end

    assign drive_en  = !park && !out_off;
    assign ph1_mag   = mag[0];
    assign ph1_neg   = neg[0];
    assign ph2_mag   = mag[1];
    assign ph2_neg   = neg[1];
    assign ph1_mixed = mixed[0];
    assign ph2_mixed = mixed[1];

endmodule

// File: rtl/ustep_translator_chk.sv
module ustep_translator_chk
    import ustep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       park,
    input logic       out_off,
    input logic       drive_en,
    input logic       adv,
    input idx_t       idx,
    input logic [7:0] ph1_mag,
    input logic       ph1_neg,
    input logic [7:0] ph2_mag,
    input logic       ph2_neg,
    input logic       ph1_mixed,
    input logic       ph2_mixed
);

    AST_PARK_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> (ph1_mag == HOME_MAG && ph2_mag == HOME_MAG && !ph1_neg && !ph2_neg)); // R4
    AST_PARK_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        park |-> !drive_en); // R5
    AST_PARK_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        park |-> !adv); // R5
    AST_ZERO_POS_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_mag == 8'd0) |-> !ph1_neg); // R3
    AST_ZERO_POS_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_mag == 8'd0) |-> !ph2_neg); // R3
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !park) |=> $stable(idx)); // R8
    AST_DECAY_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !park) |=> (ph1_mixed == (ph1_mag < $past(ph1_mag)))); // R9
    AST_DECAY_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !park) |=> (ph2_mixed == (ph2_mag < $past(ph2_mag)))); // R9
    AST_PARK_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> (ph1_mixed && ph2_mixed)); // R10
    AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_off |-> !drive_en); // R11

endmodule

bind ustep_translator ustep_translator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .park      (park),
    .out_off   (out_off),
    .drive_en  (drive_en),
    .adv       (adv),
    .idx       (idx),
    .ph1_mag   (ph1_mag),
    .ph1_neg   (ph1_neg),
    .ph2_mag   (ph2_mag),
    .ph2_neg   (ph2_neg),
    .ph1_mixed (ph1_mixed),
    .ph2_mixed (ph2_mixed)
);

// File: tb/ustep_translator_bench.sv
module ustep_translator_bench;

    localparam int MINH = 8;

    logic       clk = 1'b0;
    logic       rst_n, park, out_off, step_in, dir_in;
    logic [1:0] res_sel;
    logic       drive_en, ph1_neg, ph2_neg, ph1_mixed, ph2_mixed;
    logic [7:0] ph1_mag, ph2_mag;

    always #2 clk = ~clk;

    ustep_translator #(.MIN_HIGH(MINH)) u_ustep_translator (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int idx_m;
    bit mix_m [2];

    function automatic int qtab(input int k);
        int t [17] = '{255,254,250,244,236,225,212,197,180,162,142,120,98,74,50,25,0};
        return t[k];
    endfunction

    function automatic int fold(input int a);
        if (a <= 16) return a;
        if (a <= 32) return 32 - a;
        if (a <= 48) return a - 32;
        return 64 - a;
    endfunction

    function automatic int angle_of(input int p, input int i);
        return (p == 0) ? i : (i + 48) % 64;
    endfunction

    function automatic int e_mag(input int p, input int i);
        return qtab(fold(angle_of(p, i)));
    endfunction

    function automatic int e_neg(input int p, input int i);
        int a = angle_of(p, i);
        return (a > 16 && a < 48) ? 1 : 0;
    endfunction

    function automatic int e_stride(input logic [1:0] s);
        case (s)
            2'b00:   return 16;
            2'b10:   return 8;
            2'b01:   return 4;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " ph1_mag"}, ph1_mag, e_mag(0, idx_m));
        chk({req, " ph1_neg"}, ph1_neg, e_neg(0, idx_m));
        chk({req, " ph2_mag"}, ph2_mag, e_mag(1, idx_m));
        chk({req, " ph2_neg"}, ph2_neg, e_neg(1, idx_m));
        chk({req, " ph1_mixed"}, ph1_mixed, mix_m[0]);
        chk({req, " ph2_mixed"}, ph2_mixed, mix_m[1]);
        chk({req, " drive_en"}, drive_en, (!park && !out_off) ? 1 : 0);
    endtask

    task automatic go_home();
        idx_m    = 8;
        mix_m[0] = 1'b1;
        mix_m[1] = 1'b1;
    endtask

    // one pulse of hi clocks; flip toggles direction while high
    task automatic pulse(input bit d, input logic [1:0] s, input int hi, input bit flip);
        @(negedge clk);
        dir_in  = d;
        res_sel = s;
        repeat (4) @(negedge clk);
        step_in = 1'b1;
        for (int c = 0; c < hi; c++) begin
            @(negedge clk);
            if (flip && c == 2) begin
                dir_in  = ~d;
                res_sel = ~s;
            end
        end
        step_in = 1'b0;
        repeat (5) @(negedge clk);
        if (hi >= MINH && !park) begin
            int old_i = idx_m;
            int new_i = d ? (old_i + e_stride(s)) % 64 : (old_i - e_stride(s) + 64) % 64;
            for (int p = 0; p < 2; p++) mix_m[p] = e_mag(p, new_i) < e_mag(p, old_i);
            idx_m = new_i;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; park = 1'b0; out_off = 1'b0;
        step_in = 1'b0; dir_in = 1'b1; res_sel = 2'b00;
        go_home();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R4 R10 reset");

        pulse(1'b1, 2'b00, MINH, 1'b0);
        check_all("R1 R6 full up");
        pulse(1'b0, 2'b10, MINH, 1'b0);
        check_all("R1 R6 half down");
        pulse(1'b1, 2'b01, MINH, 1'b0);
        check_all("R1 R9 quarter up");

        for (int n = 0; n < 64; n++) begin
            pulse(1'b1, 2'b11, MINH, 1'b0);
            check_all("R2 R3 R9 sixteenth sweep");
        end

        pulse(1'b1, 2'b11, MINH - 1, 1'b0);
        check_all("R8 short pulse");
        pulse(1'b1, 2'b11, MINH, 1'b0);
        check_all("R8 exact minimum");

        pulse(1'b0, 2'b00, MINH + 4, 1'b1);
        check_all("R7 change while high");

        pulse(1'b1, 2'b11, MINH, 1'b0);
        pulse(1'b1, 2'b01, MINH, 1'b0);
        check_all("R12 unaligned quarter");
        pulse(1'b0, 2'b00, MINH, 1'b0);
        check_all("R12 unaligned full");

        for (int n = 0; n < 6; n++) begin
            pulse(1'b0, 2'b00, MINH, 1'b0);
            check_all("R6 wrap down");
        end

        @(negedge clk); out_off = 1'b1;
        pulse(1'b1, 2'b10, MINH, 1'b0);
        check_all("R11 output off keeps stepping");
        @(negedge clk); out_off = 1'b0;

        @(negedge clk); park = 1'b1;
        go_home();
        pulse(1'b1, 2'b00, MINH + 2, 1'b0);
        check_all("R4 R5 R10 parked");
        @(negedge clk); park = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R4 R10 after park");

        void'($urandom(32'd20240611));
        for (int n = 0; n < 200; n++) begin
            bit       d    = 1'($urandom_range(0, 1));
            logic [1:0] s  = 2'($urandom_range(0, 3));
            int       hi   = $urandom_range(MINH - 2, MINH + 3);
            @(negedge clk);
            out_off = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 24) == 0) begin
                park = 1'b1;
                go_home();
                pulse(d, s, hi, 1'b0);
                check_all("R5 random park");
                @(negedge clk); park = 1'b0;
                repeat (3) @(negedge clk);
            end else begin
                pulse(d, s, hi, 1'($urandom_range(0, 3) == 0));
                check_all("R1 R6 R8 R9 R11 random");
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule